// File: doc/BRIEF.md
# I2C Slave Register Bank with Auto-Incrementing Pointer

This block is a slave on a two-wire serial bus. It holds a small bank of byte-wide registers that a bus master can write and read. Both bus lines are open-drain: the block samples SCL and SDA as inputs and pulls SDA low through an output enable. A separate combinational read port lets local logic inspect any register at any time.

A single internal pointer selects the register that the next bus byte touches. In a write transaction, the first byte after the address is a pointer value. Every byte after that is stored at the pointer, and the pointer then advances. In a read transaction, the block returns the register at the pointer and advances the pointer for each byte the master accepts. The pointer wraps at the bank size. It keeps its value from one transaction to the next, so a master can set the pointer in a short write and then read from that position after a repeated START or a new START.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset every register reads zero, the pointer is zero and SDA is released (sdaOe low).
- R2: An address byte whose upper seven bits equal 0x55 is acknowledged by pulling SDA low during the ninth SCL pulse. Bit 0 of the address byte selects the direction: 0 means write and 1 means read.
- R3: An address byte for any other slave address, including the general-call value 0x00, is not acknowledged. The block keeps SDA released for the rest of that transaction, and no register changes.
- R4: In a write transaction, the first data byte loads the pointer with the byte value modulo 16. That byte is acknowledged and is not stored in any register.
- R5: Every later data byte of the same write transaction is acknowledged, stored at the pointer, and then the pointer advances by one.
- R6: In a read transaction, the block sends the register at the pointer, MSB first, and the pointer advances by one. Each byte the master acknowledges is followed by the next register.
- R7: The pointer wraps from 15 to 0 for both reads and writes.
- R8: After the master NACKs a read byte, the block releases SDA until the next STOP or START, and the pointer does not advance any further.
- R9: A repeated START restarts address reception. The pointer keeps its value across STOP, START and repeated START.
- R10: sdaOe changes only while the synchronized SCL is low.
- R11: The local read port returns the register selected by rdAddr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | When high, pulls the data line low |
| rdAddr | input | 4 | Register index for the local read port |
| rdData | output | 8 | Contents of the register at rdAddr |

## Verification
The assertions watch every cycle and check three things. The pointer loads correctly from the first write byte. It advances and wraps on every store and every read load. The data-line enable never moves while the synchronized clock is high, and both come out of reset in the right state. The address match, the ACK/NACK bits, the byte order of reads, the wrap-around across a whole transaction and the silent behaviour after a refused address or a master NACK can only be shown by the bench's bus scenarios. These include a sweep of all 128 slave addresses.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  // Strobes sent from the bus controller to the register datapath
  typedef struct packed {
    logic ptrLoad;  // received byte becomes the pointer
    logic wrEn;     // received byte stored at the pointer
    logic ptrInc;   // pointer advances (store or read load)
  } rbStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_SET,
    ST_ACK_HOLD,
    ST_WDATA,
    ST_RDATA,
    ST_RACK,
    ST_RLOAD,
    ST_WAIT
  } rbState_t;

endpackage

// File: rtl/rb_datapath.sv
module rb_datapath
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  parameter int PTR_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  rbStrobe_t         stb,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [PTR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] rdData,
  output logic [PTR_W-1:0]  ptr
);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [PTR_W-1:0]  ptrNext;

  assign ptrNext = (ptr == PTR_W'(NUM_REGS - 1)) ? '0 : PTR_W'(ptr + 1'b1);

  always_ff @(posedge clk) begin
    if (rst)              ptr <= '0;
    else if (stb.ptrLoad) ptr <= PTR_W'(rxByte % NUM_REGS);
    else if (stb.ptrInc)  ptr <= ptrNext;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                  regs[g] <= '0;
      else if (stb.wrEn && ptr == PTR_W'(g))    regs[g] <= rxByte;
    end
  end

  assign txData = regs[ptr];
  assign rdData = regs[rdAddr];

endmodule

// File: rtl/rb_ctrl.sv
module rb_ctrl
  import regbank_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter logic [6:0]  SLAVE_ADDR = 7'h55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [DATA_W-1:0] txData,
  output rbStrobe_t         stb,
  output logic [DATA_W-1:0] rxByte,
  output logic              sdaOe,
  output logic              sclSync
);

  localparam int BIT_W = $clog2(DATA_W);

  logic [1:0] sclPipe, sdaPipe;
  logic       sclD, sdaD, sclS, sdaS;
  logic       sclRise, sclFall, startCond, stopCond;
  rbState_t   state;
  logic [BIT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shiftReg, rxNext;
  logic       isRead, expectPtr, lastBit, loadTx, byteDone;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclPipe <= 2'b11;
      sdaPipe <= 2'b11;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[0], sclIn};
      sdaPipe <= {sdaPipe[0], sdaIn};
      sclD    <= sclPipe[1];
      sdaD    <= sdaPipe[1];
    end
  end

  assign sclS      = sclPipe[1];
  assign sdaS      = sdaPipe[1];
  assign sclSync   = sclS;
  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startCond = sclS & sclD & sdaD & ~sdaS;
  assign stopCond  = sclS & sclD & ~sdaD & sdaS;
  assign lastBit   = (bitCnt == BIT_W'(DATA_W - 1));
  assign rxNext    = {shiftReg[DATA_W-2:0], sdaS};
  assign rxByte    = rxNext;

  assign loadTx   = sclFall & ((state == ST_ACK_HOLD && isRead) || state == ST_RLOAD);
  assign byteDone = sclRise & lastBit & (state == ST_WDATA);

  always_comb begin
    stb.ptrLoad = byteDone & expectPtr;
    stb.wrEn    = byteDone & ~expectPtr;
    stb.ptrInc  = loadTx | stb.wrEn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      shiftReg  <= '0;
      isRead    <= 1'b0;
      expectPtr <= 1'b0;
      sdaOe     <= 1'b0;
    end else if (startCond) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (stopCond) begin
      state <= ST_IDLE;
      sdaOe <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: if (sclRise) begin
          shiftReg <= rxNext;
          bitCnt   <= BIT_W'(bitCnt + 1'b1);
          if (lastBit) begin
            if (rxNext[DATA_W-1:1] == SLAVE_ADDR) begin
              state     <= ST_ACK_SET;
              isRead    <= rxNext[0];
              expectPtr <= 1'b1;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_ACK_SET: if (sclFall) begin
          sdaOe <= 1'b1;
          state <= ST_ACK_HOLD;
        end
        ST_ACK_HOLD, ST_RLOAD: if (sclFall) begin
          bitCnt <= '0;
          if (loadTx) begin
            shiftReg <= txData;
            sdaOe    <= ~txData[DATA_W-1];
            state    <= ST_RDATA;
          end else begin
            sdaOe <= 1'b0;
            state <= ST_WDATA;
          end
        end
        ST_WDATA: if (sclRise) begin
          shiftReg <= rxNext;
          bitCnt   <= BIT_W'(bitCnt + 1'b1);
          if (lastBit) begin
            expectPtr <= 1'b0;
            state     <= ST_ACK_SET;
          end
        end
        ST_RDATA: if (sclFall) begin
          if (lastBit) begin
            sdaOe <= 1'b0;
            state <= ST_RACK;
          end else begin
            shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
            sdaOe    <= ~shiftReg[DATA_W-2];
            bitCnt   <= BIT_W'(bitCnt + 1'b1);
          end
        end
        ST_RACK: if (sclRise) state <= sdaS ? ST_WAIT : ST_RLOAD;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
  import regbank_pkg::*;
#(
  parameter int         NUM_REGS   = 16,
  parameter int         DATA_W     = 8,
  parameter logic [6:0] SLAVE_ADDR = 7'h55
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  output logic                        sdaOe,
  input  logic [$clog2(NUM_REGS)-1:0] rdAddr,
  output logic [DATA_W-1:0]           rdData
);

  localparam int PTR_W = $clog2(NUM_REGS);

  rbStrobe_t         stb;
  logic [DATA_W-1:0] rxByte, txData;
  logic [PTR_W-1:0]  ptrVal;
  logic              sclSync;

  rb_ctrl #(.DATA_W(DATA_W), .SLAVE_ADDR(SLAVE_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .sclIn(sclIn), .sdaIn(sdaIn), .txData(txData),
    .stb(stb), .rxByte(rxByte), .sdaOe(sdaOe), .sclSync(sclSync)
  );

  rb_datapath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .rxByte(rxByte), .rdAddr(rdAddr),
    .txData(txData), .rdData(rdData), .ptr(ptrVal)
  );

endmodule

// File: rtl/rb_checker.sv
module rb_checker
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  parameter int PTR_W    = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst,
  input rbStrobe_t         stb,
  input logic [PTR_W-1:0]  ptr,
  input logic [DATA_W-1:0] rxByte,
  input logic              sdaOe,
  input logic              sclSync
);

  // R1: state right after reset
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ptr == '0 && !sdaOe));

  // R4: first write byte becomes the pointer, modulo bank size
  p_ptr_load_r4: assert property (@(posedge clk) disable iff (rst)
    stb.ptrLoad |=> ptr == PTR_W'($past(rxByte) % NUM_REGS));

  // R7: every advance is +1 with wrap-around
  p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (stb.ptrInc && !stb.ptrLoad) |=> ptr == PTR_W'(($past(ptr) + 1) % NUM_REGS));

  // R10: data enable only moves while clock is low
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdaOe) |-> !sclSync);

endmodule

bind i2c_regbank_slave rb_checker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .stb(stb), .ptr(ptrVal), .rxByte(rxByte),
  .sdaOe(sdaOe), .sclSync(sclSync)
);

// File: tb/i2c_regbank_slave_tb_top.sv
module i2c_regbank_slave_tb_top;

  localparam int Q = 6;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sdaOe;
  logic [3:0] rdAddr = '0;
  logic [7:0] rdData;
  wire  sdaBus = mSda & ~sdaOe;

  int total = 0, bad = 0;
  bit done = 0, oeBad = 0, prevOe = 0;
  logic [7:0] model [N];
  int mptr = 0;

  always #10 clk = ~clk;

  i2c_regbank_slave dut_i (
    .clk(clk), .rst(rst), .sclIn(mScl), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  // R10 monitor: enable never moves while the bus clock is high
  always @(negedge clk) begin
    if (!rst && sdaOe != prevOe && mScl) oeBad = 1;
    prevOe = sdaOe;
  end

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q; repeat (Q) @(negedge clk); endtask

  task automatic busStart;
    mSda = 1; q; mScl = 1; q; mSda = 0; q; mScl = 0; q;
  endtask

  task automatic busStop;
    mSda = 0; q; mScl = 1; q; mSda = 1; q;
  endtask

  task automatic putBit(input logic b);
    mSda = b; q; mScl = 1; q; q; mScl = 0; q;
  endtask

  task automatic getBit(output logic b);
    mSda = 1; q; mScl = 1; q; b = sdaBus; q; mScl = 0; q;
  endtask

  task automatic writeByte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    ack = ~b;
  endtask

  task automatic readByte(output logic [7:0] v, input bit ack);
    logic b;
    for (int i = 0; i < 8; i++) begin getBit(b); v = {v[6:0], b}; end
    putBit(~ack);
  endtask

  task automatic wrTxn(input logic [7:0] p, input int n, input int base);
    bit ack;
    busStart;
    writeByte({7'h55, 1'b0}, ack); chk(ack, "R2 write address ack", ack, 1);
    writeByte(p, ack);             chk(ack, "R4 pointer byte ack", ack, 1);
    mptr = p % N;
    for (int k = 0; k < n; k++) begin
      writeByte(pat(base + k), ack); chk(ack, "R5 data byte ack", ack, 1);
      model[mptr] = pat(base + k);
      mptr = (mptr + 1) % N;
    end
    busStop;
  endtask

  task automatic rdTxn(input int n, input bit restart);
    bit ack; logic [7:0] v;
    if (restart) begin mSda = 1; q; mScl = 1; q; mSda = 0; q; mScl = 0; q; end
    else busStart;
    writeByte({7'h55, 1'b1}, ack); chk(ack, "R2 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      readByte(v, k != n - 1);
      chk(v == model[mptr], "R6 R7 read data", v, model[mptr]);
      mptr = (mptr + 1) % N;
    end
  endtask

  task automatic localCheck(input string tag);
    for (int a = 0; a < N; a++) begin
      rdAddr = 4'(a); @(negedge clk);
      chk(rdData == model[a], tag, rdData, model[a]);
    end
  endtask

  initial begin
    bit ack; logic b; logic [7:0] v;
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(sdaOe == 0, "R1 sda released", sdaOe, 0);
    localCheck("R1 R11 reset zero");

    // Fill the bank from pointer 0
    wrTxn(8'h00, N, 0);
    localCheck("R5 R11 bank after fill");

    // Pointer-only write: no data stored
    wrTxn(8'h25, 0, 0);
    localCheck("R4 pointer byte not stored");
    rdTxn(2, 0); busStop;
    chk(mptr == 7, "R9 pointer persisted across STOP", mptr, 7);

    // Wrap on write: start at 14, four bytes
    wrTxn(8'h0E, 4, 100);
    localCheck("R7 write wrap");

    // Pointer set, then repeated START into a read that wraps
    busStart;
    writeByte({7'h55, 1'b0}, ack); chk(ack, "R2 address ack", ack, 1);
    writeByte(8'h00, ack);         chk(ack, "R4 pointer ack", ack, 1);
    mptr = 0;
    rdTxn(18, 1);
    // R8: after NACK the slave keeps SDA released
    for (int i = 0; i < 9; i++) begin
      getBit(b); chk(b == 1'b1, "R8 released after NACK", b, 1);
    end
    busStop;
    rdTxn(1, 0); busStop;
    chk(mptr == 3, "R8 pointer stopped after NACK", mptr, 3);

    // Address sweep with write direction
    for (int a = 0; a < 128; a++) begin
      busStart;
      writeByte({7'(a), 1'b0}, ack);
      if (a == 8'h55) begin
        chk(ack, "R2 sweep match ack", ack, 1);
      end else begin
        chk(!ack, a == 0 ? "R3 general call nack" : "R3 mismatch nack", ack, 0);
        writeByte(8'hFF, ack); chk(!ack, "R3 data after mismatch nack", ack, 0);
      end
      busStop;
    end
    localCheck("R3 bank untouched by mismatches");
    rdTxn(1, 0); busStop;

    chk(!oeBad, "R10 sdaOe stable while SCL high", oeBad, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule